// File: doc/BRIEF.md
# Parallel Configuration Host Sequencer

This block is the host side of an 8-bit parallel configuration link for a programmable logic device. On a start request it pulls the active-low configuration-start line low for a fixed number of system clocks and then releases it. It then waits, with a timeout, for the target's open-drain status line to read high. Only after that does it stream bitstream bytes onto an 8-bit data bus, next to a data clock that it derives from the system clock.

Bytes arrive on a valid/ready stream. One byte is taken at the start of each byte slot. A slot is one data-clock period in plain mode, or four periods in the compressed/secure pacing mode, where the target latches only every fourth rising edge. When the target raises its done line, the block sends a set number of extra data-clock cycles for initialization and then flags completion. If the status line drops while a load is under way, the block halts with an error and waits for a retry request. The retry replays the start pulse.

The status and done inputs must already be synchronous to `clk_i`.

Top module: `cfg_host_seq`

## Requirements
- R1: While reset is applied and right after it, `ncfg_o` is 1, `dclk_o` is 0, and `s_ready_o`, `err_o` and `done_o` are 0.
- R2: A cycle with `start_i` high, in the idle or completed state, drives `ncfg_o` low for exactly `NCFG_LOW_CYC` system clocks. `dclk_o` stays low while `ncfg_o` is low.
- R3: No byte is accepted and no data-clock edge is produced until `status_i` reads high. If `status_i` is still low `STAT_TIMEOUT_CYC` clocks after `ncfg_o` rises, `err_o` goes high in that cycle.
- R4: With `mode_i`=0 latched, each accepted byte yields exactly one `dclk_o` rising edge. `dclk_o` has a period of `DCLK_DIV` clocks with equal high and low halves. `data_o` changes only in the cycle right after an accept, while `dclk_o` is low, and holds through every high phase.
- R5: With `mode_i`=1 latched, each accepted byte stays on `data_o` for exactly four `dclk_o` rising edges before the next byte is taken.
- R6: `s_ready_o` is high only at a byte-slot boundary. While no byte is offered at a boundary, `dclk_o` stays low, no rising edge occurs, and `s_ready_o` stays high.
- R7: When `done_i` is high at a slot boundary, no further byte is accepted. Exactly `INIT_DCLKS` more rising edges follow, then `done_o` goes high and `s_ready_o` stays low.
- R8: If `status_i` falls during streaming or initialization, `dclk_o` and `s_ready_o` drop within one clock, `err_o` goes high, and no further edges occur. A `retry_i` pulse then drives a new `NCFG_LOW_CYC` low pulse on `ncfg_o`.
- R9: `mode_i` is sampled only on the start or retry cycle. Changing it during a load does not alter the pacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration run |
| retry_i | input | 1 | Restart after an error |
| mode_i | input | 1 | 0: one data clock per byte, 1: four per byte |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte offered |
| s_ready_o | output | 1 | Byte taken this cycle when valid |
| ncfg_o | output | 1 | Configuration-start line, active low |
| status_i | input | 1 | Target status line as read back (high = released) |
| done_i | input | 1 | Target done line |
| dclk_o | output | 1 | Generated data clock |
| data_o | output | 8 | Byte presented to the target |
| err_o | output | 1 | Timeout or status loss |
| done_o | output | 1 | Configuration and initialization complete |

## Verification
The bench exercises the start pulse length and the status timeout at their exact cycle counts. A wrong counter end value shows up as a pulse or timeout that is off by one. In four-edge mode it checks that every byte appears on all four rising edges. A slot counter that misses a beat would then advance the byte early, and a stray edge during a stream stall would let the target latch an absent byte. It drops the status line in the middle of a stream and requires the data clock to stop at once and a retry to replay the start pulse. It flips the mode input during loads to catch pacing that is read live and not latched.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_WAIT,
    ST_DATA,
    ST_INIT,
    ST_DONE,
    ST_ERR
  } cfg_state_e;

  localparam int unsigned SECURE_BEATS = 4;
endpackage

// File: rtl/cfg_dclk_gen.sv
module cfg_dclk_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic dclk_o,
  output logic cyc_end_o
);
  localparam int unsigned PH_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

  logic [PH_W-1:0] ph_q;
  logic            hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      hi_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      ph_q <= '0;
      hi_q <= 1'b0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
      hi_q <= ~hi_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign dclk_o    = hi_q;
  assign cyc_end_o = en_i && !clr_i && hi_q && (ph_q == PH_LAST);

  // R6
  edge_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> $past(en_i));
endmodule

// File: rtl/cfg_host_fsm.sv
module cfg_host_fsm
  import cfg_host_pkg::*;
#(
  parameter int unsigned NCFG_LOW_CYC     = 8,
  parameter int unsigned STAT_TIMEOUT_CYC = 1000,
  parameter int unsigned INIT_DCLKS       = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       retry_i,
  input  logic       mode_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  output logic       s_ready_o,
  input  logic       status_i,
  input  logic       done_i,
  input  logic       cyc_end_i,
  output logic       run_o,
  output logic       clr_o,
  output logic       ncfg_o,
  output logic [7:0] data_o,
  output logic       err_o,
  output logic       done_o
);
  localparam int unsigned MAX_A   = (NCFG_LOW_CYC > STAT_TIMEOUT_CYC) ? NCFG_LOW_CYC : STAT_TIMEOUT_CYC;
  localparam int unsigned CNT_MAX = (MAX_A > INIT_DCLKS) ? MAX_A : INIT_DCLKS;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(NCFG_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] TO_END   = CNT_W'(STAT_TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_DCLKS - 1);
  localparam logic [1:0]       BEAT_END = 2'(SECURE_BEATS - 1);

  cfg_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beat_q;
  logic             run_q;
  logic             mode_q;
  logic [7:0]       data_q;

  logic in_load, stat_lost, beat_last, slot_bnd, begin_run;

  always_comb begin
    in_load   = (state_q == ST_DATA) || (state_q == ST_INIT);
    stat_lost = in_load && !status_i;
    beat_last = !mode_q || (beat_q == BEAT_END);
    slot_bnd  = (state_q == ST_DATA) && (!run_q || (cyc_end_i && beat_last));
    s_ready_o = slot_bnd && status_i && !done_i;
    begin_run = (((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i) ||
                ((state_q == ST_ERR) && retry_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      data_q  <= '0;
    end else if (begin_run) begin
      state_q <= ST_RST;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      mode_q  <= mode_i;
    end else begin
      unique case (state_q)
        ST_RST: begin
          if (cnt_q == LOW_END) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (status_i) begin
            state_q <= ST_DATA;
            run_q   <= 1'b0;
            beat_q  <= '0;
          end else if (cnt_q == TO_END) begin
            state_q <= ST_ERR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (stat_lost) begin
            state_q <= ST_ERR;
            run_q   <= 1'b0;
          end else if (slot_bnd) begin
            if (done_i) begin
              state_q <= ST_INIT;
              run_q   <= 1'b1;
              cnt_q   <= '0;
            end else if (s_valid_i) begin
              data_q <= s_data_i;
              run_q  <= 1'b1;
              beat_q <= '0;
            end else begin
              run_q <= 1'b0;
            end
          end else if (cyc_end_i) begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_INIT: begin
          if (stat_lost) begin
            state_q <= ST_ERR;
            run_q   <= 1'b0;
          end else if (cyc_end_i) begin
            if (cnt_q == INIT_END) begin
              state_q <= ST_DONE;
              run_q   <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_IDLE, ST_DONE, ST_ERR: ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = run_q;
  assign clr_o  = stat_lost;
  assign ncfg_o = (state_q != ST_RST);
  assign data_o = data_q;
  assign err_o  = (state_q == ST_ERR);
  assign done_o = (state_q == ST_DONE);

  // R3
  ready_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> status_i);
  // R7
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!s_ready_o && !run_o));
  // R8
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!s_ready_o && !run_o));
endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq #(
  parameter int unsigned DCLK_DIV         = 4,
  parameter int unsigned NCFG_LOW_CYC     = 8,
  parameter int unsigned STAT_TIMEOUT_CYC = 1000,
  parameter int unsigned INIT_DCLKS       = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       retry_i,
  input  logic       mode_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  output logic       s_ready_o,
  output logic       ncfg_o,
  input  logic       status_i,
  input  logic       done_i,
  output logic       dclk_o,
  output logic [7:0] data_o,
  output logic       err_o,
  output logic       done_o
);
  localparam int unsigned HALF = (DCLK_DIV < 2) ? 1 : DCLK_DIV / 2;

  logic run, clr, cyc_end;

  cfg_dclk_gen #(.HALF(HALF)) i_dclk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (run),
    .clr_i     (clr),
    .dclk_o    (dclk_o),
    .cyc_end_o (cyc_end)
  );

  cfg_host_fsm #(
    .NCFG_LOW_CYC     (NCFG_LOW_CYC),
    .STAT_TIMEOUT_CYC (STAT_TIMEOUT_CYC),
    .INIT_DCLKS       (INIT_DCLKS)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .retry_i   (retry_i),
    .mode_i    (mode_i),
    .s_data_i  (s_data_i),
    .s_valid_i (s_valid_i),
    .s_ready_o (s_ready_o),
    .status_i  (status_i),
    .done_i    (done_i),
    .cyc_end_i (cyc_end),
    .run_o     (run),
    .clr_o     (clr),
    .ncfg_o    (ncfg_o),
    .data_o    (data_o),
    .err_o     (err_o),
    .done_o    (done_o)
  );

  // R4
  data_hold_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> $stable(data_o));
  // R4
  accept_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ready_o && s_valid_i) |=> !dclk_o);
  // R2
  pulse_no_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ncfg_o |-> (!dclk_o && !s_ready_o));
  // R8
  err_no_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !dclk_o);
endmodule

// File: tb/test_cfg_host_seq.sv
module test_cfg_host_seq;
  localparam int DIV  = 4;
  localparam int NCFG = 5;
  localparam int TO   = 20;
  localparam int INIT = 3;

  // row: {mode, len[6:0], expected rising edges[7:0]}
  localparam logic [15:0] ROWS [4] = '{
    {1'b0, 7'd8, 8'd11},
    {1'b1, 7'd3, 8'd15},
    {1'b0, 7'd1, 8'd4},
    {1'b1, 7'd2, 8'd11}
  };
  localparam logic [7:0] PAT [8] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h5A, 8'hC3, 8'h81, 8'h7E};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, retry = 1'b0, mode = 1'b0, s_valid = 1'b0, status = 1'b0, done_in = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, ncfg, dclk, err, done_out;
  logic [7:0] data;

  int total = 0, bad = 0;
  int rise_cnt, min_gap, since_rise, stab_viol, low_run, last_low, t_cyc, t_ncfg_up, t_err, ready_seen;
  bit have_rise, kill;
  int stat_dly = 3;
  logic [7:0] cap [64];
  logic prev_dclk, prev_ncfg, prev_err;
  logic [7:0] prev_data;

  always #2 clk = ~clk;

  cfg_host_seq #(.DCLK_DIV(DIV), .NCFG_LOW_CYC(NCFG), .STAT_TIMEOUT_CYC(TO), .INIT_DCLKS(INIT)) i_cfg_host_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .retry_i(retry), .mode_i(mode),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready), .ncfg_o(ncfg),
    .status_i(status), .done_i(done_in), .dclk_o(dclk), .data_o(data),
    .err_o(err), .done_o(done_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // target model: holds status low while start line low or killed, releases after a delay
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (!ncfg) begin status = 1'b0; dly = 0; end
      else if (kill) status = 1'b0;
      else if (!status && t_cyc > 0) begin
        if (dly >= stat_dly) status = 1'b1; else dly++;
      end
    end
  end

  // monitor samples 1 ns after each rising edge
  initial begin
    t_cyc = 0; prev_dclk = 0; prev_ncfg = 1; prev_err = 0; prev_data = '0;
    forever begin
      @(posedge clk); #1;
      t_cyc++;
      since_rise++;
      if (s_ready) ready_seen++;
      if (dclk && data != prev_data) stab_viol++;
      if (dclk && !prev_dclk) begin
        if (rise_cnt < 64) cap[rise_cnt] = data;
        rise_cnt++;
        if (have_rise && since_rise < min_gap) min_gap = since_rise;
        have_rise = 1; since_rise = 0;
      end
      if (!ncfg) low_run++;
      if (ncfg && !prev_ncfg) begin last_low = low_run; t_ncfg_up = t_cyc; end
      if (ncfg) low_run = 0;
      if (err && !prev_err) t_err = t_cyc;
      prev_dclk = dclk; prev_ncfg = ncfg; prev_err = err; prev_data = data;
    end
  end

  task automatic clear_mon();
    rise_cnt = 0; min_gap = 1000; since_rise = 0; stab_viol = 0; have_rise = 0;
    last_low = 0; ready_seen = 0; t_err = 0; t_ncfg_up = 0;
  endtask

  task automatic start_cfg(input logic m);
    @(negedge clk); clear_mon();
    mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    mode = ~m; // R9: ignored after the start cycle
  endtask

  task automatic feed(input int len, input int gap_at, input int gap_len);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at && gap_len > 0) begin
        int snap;
        s_valid = 1'b0;
        repeat (2*DIV + 2) @(negedge clk);
        chk(dclk == 0 && s_ready == 1, "R6 stall idle", {dclk, s_ready}, 1);
        snap = rise_cnt;
        repeat (gap_len) @(negedge clk);
        chk(rise_cnt == snap && dclk == 0, "R6 no edge in stall", rise_cnt, snap);
      end
      s_valid = 1'b1; s_data = PAT[i % 8];
      while (!s_ready && !err) @(negedge clk);
      if (err) break;
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic finish_load(input logic m, input int len, input int exp_rises);
    int step, mism;
    step = m ? 4 : 1;
    repeat (2*DIV + 4) @(negedge clk);
    done_in = 1'b1;
    for (int k = 0; k < 500 && !done_out; k++) @(negedge clk);
    done_in = 1'b0;
    chk(done_out == 1, "R7 done flag", done_out, 1);
    chk(rise_cnt == exp_rises, m ? "R5 R7 R9 edge count" : "R4 R7 R9 edge count", rise_cnt, exp_rises);
    mism = 0;
    for (int k = 0; k < len * step; k++) if (cap[k] !== PAT[(k / step) % 8]) mism++;
    chk(mism == 0, m ? "R5 byte per four edges" : "R4 byte per edge", mism, 0);
    chk(min_gap == DIV, "R4 dclk period", min_gap, DIV);
    chk(stab_viol == 0, "R4 data stable while high", stab_viol, 0);
    chk(last_low == NCFG, "R2 start pulse length", last_low, NCFG);
    s_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_ready == 0, "R7 no accept after done", s_ready, 0);
    s_valid = 1'b0;
  endtask

  task automatic wrap_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    wrap_up();
  end

  initial begin
    clear_mon();
    kill = 0;
    repeat (3) @(negedge clk);
    chk(ncfg == 1 && dclk == 0 && s_ready == 0 && err == 0 && done_out == 0, "R1 in reset",
        {ncfg, dclk, s_ready, err, done_out}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ncfg == 1 && dclk == 0 && s_ready == 0 && err == 0 && done_out == 0, "R1 after reset",
        {ncfg, dclk, s_ready, err, done_out}, 5'b10000);

    // table walk
    for (int r = 0; r < 4; r++) begin
      start_cfg(ROWS[r][15]);
      feed(int'(ROWS[r][14:8]), -1, 0);
      finish_load(ROWS[r][15], int'(ROWS[r][14:8]), int'(ROWS[r][7:0]));
    end

    // R3: status never released
    stat_dly = 1000;
    start_cfg(1'b0);
    for (int k = 0; k < NCFG + TO + 20 && !err; k++) @(negedge clk);
    @(negedge clk);
    chk(err == 1, "R3 timeout error", err, 1);
    chk(t_err - t_ncfg_up == TO, "R3 timeout length", t_err - t_ncfg_up, TO);
    chk(rise_cnt == 0 && ready_seen == 0, "R3 quiet before status", rise_cnt + ready_seen, 0);

    // R8 retry after timeout
    stat_dly = 3;
    clear_mon();
    retry = 1'b1; mode = 1'b0; @(negedge clk); retry = 1'b0;
    feed(4, 2, 12);
    finish_load(1'b0, 4, 4 + INIT);

    // R8: status loss mid-stream
    start_cfg(1'b0);
    fork
      feed(8, -1, 0);
      begin
        wait (rise_cnt == 3);
        @(negedge clk); kill = 1;
      end
    join
    repeat (3) @(negedge clk);
    chk(err == 1 && dclk == 0 && s_ready == 0, "R8 halt on status loss", {err, dclk, s_ready}, 3'b100);
    begin
      int snap;
      snap = rise_cnt;
      repeat (10) @(negedge clk);
      chk(rise_cnt == snap, "R8 no edges after error", rise_cnt, snap);
    end
    kill = 0;
    clear_mon();
    retry = 1'b1; mode = 1'b1; @(negedge clk); retry = 1'b0; mode = 1'b0;
    feed(2, -1, 0);
    finish_load(1'b1, 2, 8 + INIT);

    wrap_up();
  end
endmodule